// File: doc/BRIEF.md
# Internal Data Memory Address Decoder

This block takes one 8-bit internal data address together with a tag that says how the address was formed. The tag is one of direct, indirect, register or bit. From these it selects exactly one physical target: the lower RAM, the upper RAM, the standard special-register space or the mapped special-register space. It also gives the 7-bit byte index inside that target and, for bit accesses, the bit position. Register numbers are folded into the active bank. Bit addresses are folded into two separate byte regions: a 16-byte window of the lower RAM, and the special registers whose address is a multiple of eight.

The two RAM arrays are built in as plain register files. Neither of them is touched by reset. Both special-register spaces are small stub files that reset to zero. They exist only so that routing can be observed. A bit write is a read-modify-write inside one clock: only the chosen bit of the target byte changes. Reads are combinational. Writes take effect on the rising clock edge.

Top module: `idm_decoder`

## Requirements
- R1: An address in 00h–7Fh with the direct or the indirect tag reaches the lower RAM at that same byte. Both tags reach the same storage.
- R2: An address in 80h–FFh reaches the upper RAM only with the indirect tag. With the direct tag it reaches a special-register space, and the upper RAM stays untouched.
- R3: With the bit tag, a bit address n in 00h–7Fh selects lower RAM byte 20h + n/8 and bit n mod 8. Bit address 00h is bit 0 of byte 20h, and 7Fh is bit 7 of byte 2Fh.
- R4: With the bit tag, a bit address b in 80h–FFh selects special-register byte (b & F8h) and bit (b & 7).
- R5: With the register tag, address bits 2–0 give the register number n. Together with the bank input they select lower RAM byte {bank, n}. Address bits 7–3 are ignored.
- R6: A special-register access, direct or by bit, goes to the mapped space when map_sel is 1 and to the standard space when map_sel is 0.
- R7: Special-register byte addresses in the shared list always reach the standard space, whatever map_sel holds. The default list is E0h, D0h and 8Fh.
- R8: A bit write changes only the selected bit of the target byte, to wdata[0], within one clock. A bit read returns that bit in rdata[0], with rdata[7:1] zero.
- R9: Reset leaves both RAM arrays unchanged. Both special-register stub files read 00h after reset.
- R10: tgt_sel is one-hot while req is high. Bit 0 means lower RAM, bit 1 upper RAM, bit 2 standard space and bit 3 mapped space. byte_idx is the 7-bit offset inside the selected target.
- R11: Storage is written only on a clock edge where both req and we are high. While req is low, tgt_sel is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request for this cycle |
| we | input | 1 | Write when high, read when low |
| addr | input | 8 | Byte, register or bit address |
| mode | input | 2 | Addressing tag: 0 direct, 1 indirect, 2 register, 3 bit |
| bank | input | 2 | Active register bank |
| map_sel | input | 1 | Selects the mapped special-register space |
| wdata | input | 8 | Write byte; bit 0 is the value for bit writes |
| tgt_sel | output | 4 | One-hot target select |
| byte_idx | output | 7 | Byte offset inside the target |
| bit_idx | output | 3 | Bit position for bit accesses |
| rdata | output | 8 | Read byte, or the selected bit in bit 0 |

## Verification
The bench goes after the places where mode and address together decide the target. One case writes upper RAM at 90h and reads it back directly. A decoder that ignored the tag would return the RAM byte instead of the special register. Other cases check the edges of the bit windows (00h, 7Fh, a bit inside 88h, E7h) and bank folding with junk in the high address bits. A wrong divide or mask there would flip a neighbouring byte or bit. Further cases set map_sel on shared addresses, where a missing exemption would send the accumulator to the mapped space. The last cases pulse reset after RAM writes, which catches a design that clears RAM along with the stubs.

// File: rtl/idm_pkg.sv
// Package: shared types for the internal data memory decoder.
// Assumes an 8-bit internal address space split into 128-byte targets.
package idm_pkg;

    typedef enum logic [1:0] {
        AM_DIRECT   = 2'd0,
        AM_INDIRECT = 2'd1,
        AM_REGISTER = 2'd2,
        AM_BIT      = 2'd3
    } amode_e;

    localparam int unsigned NUM_TGT  = 4;
    localparam int unsigned TGT_LOW  = 0;
    localparam int unsigned TGT_UP   = 1;
    localparam int unsigned TGT_STD  = 2;
    localparam int unsigned TGT_MAP  = 3;

    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned IDX_W    = ADDR_W - 1;
    localparam int unsigned TGT_DEPTH = 1 << IDX_W;

endpackage

// File: rtl/idm_shared_match.sv
// Module: flags special-register byte addresses that ignore the map select.
// Assumes the list is packed, one byte per entry, entry 0 in the low bits.
module idm_shared_match #(
    parameter int unsigned NSHARED = 3,
    parameter logic [NSHARED*8-1:0] SHARED_ADDRS = {8'h8F, 8'hD0, 8'hE0}
) (
    input  logic [7:0] sfr_byte,
    output logic       hit
);
    logic [NSHARED-1:0] eq;

    // one comparator per list entry
    for (genvar g = 0; g < NSHARED; g++) begin : g_cmp
        assign eq[g] = (sfr_byte == SHARED_ADDRS[g*8 +: 8]);
    end

    assign hit = |eq;
endmodule

// File: rtl/idm_route.sv
// Module: combinational resolver from (address, tag) to target, byte and bit.
// Assumes the caller gates the result with its own request strobe.
module idm_route
    import idm_pkg::*;
#(
    parameter int unsigned NSHARED = 3,
    parameter logic [NSHARED*8-1:0] SHARED_ADDRS = {8'h8F, 8'hD0, 8'hE0}
) (
    input  logic [ADDR_W-1:0]  addr,
    input  amode_e             mode,
    input  logic [1:0]         bank,
    input  logic               map_sel,
    output logic [NUM_TGT-1:0] tgt,
    output logic [IDX_W-1:0]   idx,
    output logic [2:0]         bit_pos,
    output logic               is_bit
);
    logic [7:0] sfr_byte;
    logic       shared_hit;
    logic       sfr_to_map;

    // special-register byte address: bit tag drops the low three bits
    assign sfr_byte = (mode == AM_BIT) ? {addr[7:3], 3'b000} : addr;

    idm_shared_match #(
        .NSHARED      (NSHARED),
        .SHARED_ADDRS (SHARED_ADDRS)
    ) i_shared (
        .sfr_byte (sfr_byte),
        .hit      (shared_hit)
    );

    // mapped space only when selected and the address is not exempt
    assign sfr_to_map = map_sel && !shared_hit;

    // target, index and bit position per addressing tag
    always_comb begin
        tgt     = '0;
        idx     = addr[IDX_W-1:0];
        bit_pos = 3'd0;
        is_bit  = 1'b0;
        unique case (mode)
            AM_DIRECT: begin
                if (!addr[7])        tgt[TGT_LOW] = 1'b1;
                else if (sfr_to_map) tgt[TGT_MAP] = 1'b1;
                else                 tgt[TGT_STD] = 1'b1;
            end
            AM_INDIRECT: begin
                if (!addr[7]) tgt[TGT_LOW] = 1'b1;
                else          tgt[TGT_UP]  = 1'b1;
            end
            AM_REGISTER: begin
                tgt[TGT_LOW] = 1'b1;
                idx          = {2'b00, bank, addr[2:0]};
            end
            AM_BIT: begin
                is_bit  = 1'b1;
                bit_pos = addr[2:0];
                if (!addr[7]) begin
                    tgt[TGT_LOW] = 1'b1;
                    idx          = {3'b010, addr[6:3]};
                end else begin
                    idx = {addr[6:3], 3'b000};
                    if (sfr_to_map) tgt[TGT_MAP] = 1'b1;
                    else            tgt[TGT_STD] = 1'b1;
                end
            end
            default: tgt = '0;
        endcase
    end
endmodule

// File: rtl/idm_bytefile.sv
// Module: byte-wide register file with whole-byte and single-bit writes.
// Assumes one access per clock; reads are combinational; reset is optional
// so that RAM instances keep their contents across reset.
module idm_bytefile #(
    parameter int unsigned DEPTH    = 128,
    parameter bit          RESET_EN = 1'b0,
    parameter logic [7:0]  RST_VAL  = 8'h00,
    localparam int unsigned AW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          bit_mode,
    input  logic [AW-1:0] idx,
    input  logic [2:0]    bit_pos,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];
    logic [7:0] mask;
    logic [7:0] next_byte;

    // read port
    assign rdata = mem[idx];

    // merge: bit writes keep every other bit of the current byte
    assign mask      = 8'b1 << bit_pos;
    assign next_byte = bit_mode ? ((rdata & ~mask) | (wdata[0] ? mask : 8'h00))
                                : wdata;

    if (RESET_EN) begin : g_rst
        // storage with synchronous clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= RST_VAL;
            end else if (wr_en) begin
                mem[idx] <= next_byte;
            end
        end
    end else begin : g_keep
        // storage that reset does not touch
        always_ff @(posedge clk) begin
            if (wr_en) mem[idx] <= next_byte;
        end
    end

    AST_BIT_WRITE_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bit_mode) |=>
        ((mem[$past(idx)] & ~$past(mask)) == ($past(rdata) & ~$past(mask)))) // R8
        else $error("bit write disturbed neighbouring bits");

    AST_BIT_WRITE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bit_mode) |=> (mem[$past(idx)][$past(bit_pos)] == $past(wdata[0]))) // R8
        else $error("bit write lost its value");
endmodule

// File: rtl/idm_decoder.sv
// Module: top of the internal data memory decoder. Resolves each access to
// one of four 128-byte targets and holds lower RAM, upper RAM and two stub
// special-register files. Assumes at most one access per clock.
module idm_decoder
    import idm_pkg::*;
#(
    parameter int unsigned NSHARED = 3,
    parameter logic [NSHARED*8-1:0] SHARED_ADDRS = {8'h8F, 8'hD0, 8'hE0}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        we,
    input  logic [7:0]  addr,
    input  logic [1:0]  mode,
    input  logic [1:0]  bank,
    input  logic        map_sel,
    input  logic [7:0]  wdata,
    output logic [3:0]  tgt_sel,
    output logic [6:0]  byte_idx,
    output logic [2:0]  bit_idx,
    output logic [7:0]  rdata
);
    logic [NUM_TGT-1:0] raw_tgt;
    logic               is_bit;
    logic [7:0]         rd_bus [NUM_TGT];
    logic [7:0]         sel_byte;

    idm_route #(
        .NSHARED      (NSHARED),
        .SHARED_ADDRS (SHARED_ADDRS)
    ) i_route (
        .addr    (addr),
        .mode    (amode_e'(mode)),
        .bank    (bank),
        .map_sel (map_sel),
        .tgt     (raw_tgt),
        .idx     (byte_idx),
        .bit_pos (bit_idx),
        .is_bit  (is_bit)
    );

    // target select is live only during a request
    assign tgt_sel = req ? raw_tgt : '0;

    // one storage file per target; the special-register stubs reset
    for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
        idm_bytefile #(
            .DEPTH    (TGT_DEPTH),
            .RESET_EN (g >= TGT_STD)
        ) i_file (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (we && tgt_sel[g]),
            .bit_mode (is_bit),
            .idx      (byte_idx),
            .bit_pos  (bit_idx),
            .wdata    (wdata),
            .rdata    (rd_bus[g])
        );
    end

    // read mux over the selected target
    always_comb begin
        sel_byte = 8'h00;
        for (int t = 0; t < NUM_TGT; t++)
            if (tgt_sel[t]) sel_byte = sel_byte | rd_bus[t];
    end

    // byte read, or the chosen bit in position 0
    assign rdata = is_bit ? {7'b0, sel_byte[bit_idx]} : sel_byte;

    AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> ($countones(tgt_sel) == 1)) // R10
        else $error("not exactly one target");

    AST_UPPER_NEEDS_INDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sel[TGT_UP] |-> (mode == 2'd1 && addr[7])) // R2
        else $error("upper RAM reached without indirect tag");

    AST_REG_IN_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 2'd2) |-> (tgt_sel[TGT_LOW] && byte_idx[6:5] == 2'b00)) // R5
        else $error("register outside bank area");

    AST_BIT_LOW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 2'd3 && !addr[7]) |-> (tgt_sel[TGT_LOW] && byte_idx[6:4] == 3'b010)) // R3
        else $error("low bit address outside 20h-2Fh");

    AST_BIT_SFR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 2'd3 && addr[7]) |-> (byte_idx[2:0] == 3'b000 && !tgt_sel[TGT_LOW])) // R4
        else $error("special-register bit not on aligned byte");

    AST_SHARED_STANDARD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 2'd0 && addr == 8'hE0) |-> tgt_sel[TGT_STD]) // R7
        else $error("accumulator address left the standard space");
endmodule

// File: tb/test_idm_decoder.sv
`timescale 1ns/1ps
module test_idm_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic       we = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [1:0] mode = 2'd0;
    logic [1:0] bank = 2'd0;
    logic       map_sel = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [3:0] tgt_sel;
    logic [6:0] byte_idx;
    logic [2:0] bit_idx;
    logic [7:0] rdata;

    int errors = 0;
    int checks = 0;

    localparam logic [1:0] DIR = 2'd0, IND = 2'd1, REG = 2'd2, BIT = 2'd3;
    localparam logic [3:0] S_LOW = 4'b0001, S_UP = 4'b0010, S_STD = 4'b0100, S_MAP = 4'b1000;

    always #2 clk = ~clk;

    idm_decoder i_idm_decoder (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .mode(mode),
        .bank(bank), .map_sel(map_sel), .wdata(wdata), .tgt_sel(tgt_sel),
        .byte_idx(byte_idx), .bit_idx(bit_idx), .rdata(rdata)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] m, input logic [7:0] a, input logic [7:0] d,
                      input logic ms, input logic [1:0] bk);
        @(negedge clk);
        req = 1'b1; we = 1'b1; mode = m; addr = a; wdata = d; map_sel = ms; bank = bk;
        @(posedge clk); #1;
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] m, input logic [7:0] a, input logic ms, input logic [1:0] bk);
        @(negedge clk);
        req = 1'b1; we = 1'b0; mode = m; addr = a; map_sel = ms; bank = bk;
        #1;
    endtask

    task automatic t_reset_state();
        @(negedge clk); req = 1'b0; #1;
        chk("R11", "idle select", tgt_sel, 4'b0000);
        rd(DIR, 8'h90, 1'b0, 2'd0);
        chk("R9", "std stub after reset", rdata, 8'h00);
        rd(DIR, 8'h90, 1'b1, 2'd0);
        chk("R9", "map stub after reset", rdata, 8'h00);
    endtask

    task automatic t_lower();
        wr(DIR, 8'h05, 8'hA5, 1'b0, 2'd0);
        rd(IND, 8'h05, 1'b0, 2'd0);
        chk("R1", "indirect read of direct write", rdata, 8'hA5);
        chk("R10", "lower select code", tgt_sel, S_LOW);
        wr(IND, 8'h7F, 8'h3C, 1'b1, 2'd0);
        rd(DIR, 8'h7F, 1'b1, 2'd0);
        chk("R1", "direct read at 7Fh", rdata, 8'h3C);
        chk("R10", "byte index at 7Fh", byte_idx, 7'h7F);
    endtask

    task automatic t_upper();
        wr(DIR, 8'h90, 8'h00, 1'b0, 2'd0);
        wr(IND, 8'h90, 8'h11, 1'b0, 2'd0);
        rd(DIR, 8'h90, 1'b0, 2'd0);
        chk("R2", "direct 90h selects std", tgt_sel, S_STD);
        chk("R2", "direct 90h not RAM", rdata, 8'h00);
        rd(IND, 8'h90, 1'b0, 2'd0);
        chk("R2", "indirect 90h selects upper", tgt_sel, S_UP);
        chk("R2", "indirect 90h data", rdata, 8'h11);
    endtask

    task automatic t_regbank();
        wr(REG, 8'h03, 8'h77, 1'b0, 2'd2);
        rd(DIR, 8'h13, 1'b0, 2'd0);
        chk("R5", "bank 2 R3 at 13h", rdata, 8'h77);
        rd(REG, 8'hFB, 1'b0, 2'd2);
        chk("R5", "high bits ignored index", byte_idx, 7'h13);
        chk("R5", "high bits ignored data", rdata, 8'h77);
        rd(REG, 8'h07, 1'b0, 2'd3);
        chk("R5", "bank 3 R7 index", byte_idx, 7'h1F);
    endtask

    task automatic t_bit_low();
        wr(DIR, 8'h2F, 8'h00, 1'b0, 2'd0);
        wr(BIT, 8'h7F, 8'h01, 1'b0, 2'd0);
        rd(DIR, 8'h2F, 1'b0, 2'd0);
        chk("R3", "bit 7Fh is 2Fh.7", rdata, 8'h80);
        wr(DIR, 8'h20, 8'hFF, 1'b0, 2'd0);
        wr(BIT, 8'h00, 8'hFE, 1'b0, 2'd0);
        rd(DIR, 8'h20, 1'b0, 2'd0);
        chk("R8", "clear bit 00h only", rdata, 8'hFE);
        rd(BIT, 8'h01, 1'b0, 2'd0);
        chk("R8", "bit read 01h", rdata, 8'h01);
        rd(BIT, 8'h3A, 1'b0, 2'd0);
        chk("R3", "bit 3Ah byte", byte_idx, 7'h27);
        chk("R3", "bit 3Ah position", bit_idx, 3'd2);
    endtask

    task automatic t_bit_sfr();
        wr(DIR, 8'h88, 8'h00, 1'b0, 2'd0);
        wr(BIT, 8'h8B, 8'h01, 1'b0, 2'd0);
        rd(DIR, 8'h88, 1'b0, 2'd0);
        chk("R4", "bit 8Bh is 88h.3", rdata, 8'h08);
        rd(BIT, 8'h8B, 1'b0, 2'd0);
        chk("R4", "bit 8Bh index", byte_idx, 7'h08);
        chk("R4", "bit 8Bh position", bit_idx, 3'd3);
    endtask

    task automatic t_map();
        wr(DIR, 8'h98, 8'h5A, 1'b1, 2'd0);
        rd(DIR, 8'h98, 1'b0, 2'd0);
        chk("R6", "map off selects std", tgt_sel, S_STD);
        chk("R6", "std untouched", rdata, 8'h00);
        rd(DIR, 8'h98, 1'b1, 2'd0);
        chk("R6", "map on selects mapped", tgt_sel, S_MAP);
        chk("R6", "mapped data", rdata, 8'h5A);
        rd(BIT, 8'h9C, 1'b1, 2'd0);
        chk("R6", "mapped bit 9Ch", rdata, 8'h01);
    endtask

    task automatic t_shared();
        wr(DIR, 8'hE0, 8'h33, 1'b1, 2'd0);
        rd(DIR, 8'hE0, 1'b0, 2'd0);
        chk("R7", "E0h shared data", rdata, 8'h33);
        rd(DIR, 8'hD0, 1'b1, 2'd0);
        chk("R7", "D0h stays std", tgt_sel, S_STD);
        rd(DIR, 8'h8F, 1'b1, 2'd0);
        chk("R7", "8Fh stays std", tgt_sel, S_STD);
        rd(BIT, 8'hE7, 1'b1, 2'd0);
        chk("R7", "bit E7h stays std", tgt_sel, S_STD);
        chk("R7", "bit E7h value", rdata, 8'h00);
    endtask

    task automatic t_no_write();
        @(negedge clk);
        req = 1'b1; we = 1'b0; mode = DIR; addr = 8'h05; wdata = 8'h00;
        @(posedge clk); #1; req = 1'b0;
        @(negedge clk);
        req = 1'b0; we = 1'b1; mode = DIR; addr = 8'h05; wdata = 8'h00;
        @(posedge clk); #1; we = 1'b0;
        rd(DIR, 8'h05, 1'b0, 2'd0);
        chk("R11", "no write without we/req", rdata, 8'hA5);
    endtask

    task automatic t_reset_keep();
        wr(DIR, 8'h40, 8'hC3, 1'b0, 2'd0);
        wr(IND, 8'hC0, 8'h96, 1'b0, 2'd0);
        wr(DIR, 8'hA0, 8'h7E, 1'b0, 2'd0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(DIR, 8'h40, 1'b0, 2'd0);
        chk("R9", "lower kept", rdata, 8'hC3);
        rd(IND, 8'hC0, 1'b0, 2'd0);
        chk("R9", "upper kept", rdata, 8'h96);
        rd(DIR, 8'hA0, 1'b0, 2'd0);
        chk("R9", "std cleared", rdata, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset_state();
        t_lower();
        t_upper();
        t_regbank();
        t_bit_low();
        t_bit_sfr();
        t_map();
        t_shared();
        t_no_write();
        t_reset_keep();
        @(negedge clk); req = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule